// File: doc/BRIEF.md
# Multi-Level Radix Table Walker

This block turns an effective address into a real address. It does so by walking a tree of 64-bit table entries that sits in memory. A caller starts a walk by giving four things: the effective address, the base of the root directory, the index width used at the root, and the total number of address bits that the tree translates. The walker then issues one memory read per tree level over a simple read port. Only one read is in flight at any time.

Each entry that is valid and is not a leaf tells the walker two things: where the next directory lives and how many index bits that directory uses. After every entry read, the remaining size shrinks by the index width that was just used. Each level has a fixed set of index widths it accepts, and the walker checks them before it reads that level. The walk ends in one of three ways: it reaches a leaf and returns the merged real address, it reads an entry that is not valid, or it finds a configuration that breaks the level rules. A one-cycle completion pulse reports the result or the fault cause.

The controller is a five-state machine:
- IDLE waits for a start.
- CHECK applies the level rule and forms the entry address.
- ISSUE holds the read request until the memory accepts it.
- AWAIT takes the returned entry.
- FINISH raises the completion pulse for one cycle.

The transitions are:
- IDLE→CHECK on start.
- CHECK→ISSUE when the level is legal.
- CHECK→FINISH on a bad configuration.
- ISSUE→AWAIT on request accept.
- AWAIT→CHECK on a valid directory entry.
- AWAIT→FINISH on a leaf or an invalid entry.
- FINISH→IDLE unconditionally.

Top module: `radix_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `done_o` and `mem_req_valid_o` are all low.
- R2: At each level the read address is the base with its low (index width + 3) bits cleared, plus 8 × ((EA >> (remaining size − index width)) masked to index-width bits).
- R3: An entry whose bit 63 is clear ends the walk. The walker issues no further read and reports fault cause 1 (no entry).
- R4: Each valid entry read reduces the remaining size by the current index width. In a directory entry (bit 62 clear), bits 59:8 give the next base (bits 7:0 taken as zero) and bits 4:0 give the next index width.
- R5: The level rules are checked before the read at each level:
  - Level 0 needs size 52 and width 13.
  - Levels 1 and 2 need width 9.
  - Level 3 needs width 9 or 5.
  - Level 4 and beyond never pass.
  A violation ends the walk with fault cause 2 (bad configuration) and no read at that level.
- R6: A leaf is an entry with bits 63 and 62 set. For a leaf, `raddr_o` is entry bits 56:12 (as an address) with the low `size` bits cleared, ORed with the low `size` bits of the EA. `page_size_o` is the remaining size and `leaf_entry_o` is the entry.
- R7: A read request stays asserted with a stable address until it is accepted. No new request is made before the response to the previous one.
- R8: `done_o` is a single-cycle pulse. `fault_o` is high with a nonzero `cause_o` on a fault. On success `fault_o` is low and `cause_o` is 0.
- R9: A start asserted while the walker is busy is ignored. `busy_o` is high from acceptance through the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| ea_i | input | 64 | Effective address to translate |
| root_base_i | input | 64 | Root directory base address |
| root_nls_i | input | NLS_W | Root index width |
| root_size_i | input | SIZE_W | Total translated size in bits |
| busy_o | output | 1 | Walk in progress |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 64 | Entry byte address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | 64 | Returned entry |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Walk ended in a fault |
| cause_o | output | 2 | 0 none, 1 no entry, 2 bad configuration |
| raddr_o | output | 64 | Translated real address |
| page_size_o | output | SIZE_W | Final page-size exponent |
| leaf_entry_o | output | 64 | Leaf entry that was found |

## Verification
The bench builds the walker with its default widths: SIZE_W = 7, NLS_W = 5 and LVL_W = 3. A 7-bit size holds the root value 52 and every value it shrinks to. A 3-bit level counter can reach level 4, so the "too deep" rejection can actually be exercised. The scenarios cover the following cases:
- walks that stop at level 1 (a 30-bit page) and at level 3 (12-bit and 16-bit pages);
- rejection at the root, at level 3 and at level 4;
- an invalid entry part-way down the tree;
- bases with stray low bits at the root and in a directory entry;
- a stalled request port combined with a start pulse during the walk.

// File: rtl/radix_walk_pkg.sv
package radix_walk_pkg;

    localparam int ENTRY_W      = 64;
    localparam int VALID_BIT    = 63;
    localparam int LEAF_BIT     = 62;
    localparam int NBASE_HI     = 59;
    localparam int NBASE_LO     = 8;
    localparam int RPN_HI       = 56;
    localparam int RPN_LO       = 12;
    localparam int ENTRY_SHIFT  = 3;   // 8-byte entries

    localparam int ROOT_SIZE    = 52;
    localparam int ROOT_WIDTH   = 13;
    localparam int MID_WIDTH    = 9;
    localparam int SMALL_WIDTH  = 5;
    localparam int DEEPEST_LVL  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_ISSUE,
        ST_AWAIT,
        ST_FINISH
    } walk_state_t;

    typedef enum logic [1:0] {
        CAUSE_NONE     = 2'd0,
        CAUSE_NO_ENTRY = 2'd1,
        CAUSE_BAD_CFG  = 2'd2
    } walk_cause_t;

endpackage

// File: rtl/radix_entry_addr.sv
module radix_entry_addr
    import radix_walk_pkg::*;
#(
    parameter int SIZE_W = 7,
    parameter int NLS_W  = 5
) (
    input  logic [ENTRY_W-1:0] ea_i,
    input  logic [ENTRY_W-1:0] base_i,
    input  logic [NLS_W-1:0]   nls_i,
    input  logic [SIZE_W-1:0]  size_i,
    output logic [ENTRY_W-1:0] addr_o
);
    localparam int AW_W = (NLS_W > SIZE_W ? NLS_W : SIZE_W) + 1;

    logic [AW_W-1:0]    align_bits;
    logic [AW_W-1:0]    shift_amt;
    logic [ENTRY_W-1:0] align_mask;
    logic [ENTRY_W-1:0] idx_mask;
    logic [ENTRY_W-1:0] index;

    always_comb begin
        align_bits = AW_W'(nls_i) + AW_W'(ENTRY_SHIFT);
        shift_amt  = AW_W'(size_i) - AW_W'(nls_i);
        align_mask = (ENTRY_W'(1) << align_bits) - ENTRY_W'(1);
        idx_mask   = (ENTRY_W'(1) << nls_i) - ENTRY_W'(1);
        index      = (ea_i >> shift_amt) & idx_mask;
        addr_o     = (base_i & ~align_mask) + (index << ENTRY_SHIFT);
    end
endmodule

// File: rtl/radix_level_rule.sv
module radix_level_rule
    import radix_walk_pkg::*;
#(
    parameter int SIZE_W = 7,
    parameter int NLS_W  = 5,
    parameter int LVL_W  = 3
) (
    input  logic [LVL_W-1:0]  level_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic [NLS_W-1:0]  nls_i,
    output logic              legal_o
);
    always_comb begin
        unique case (level_i)
            LVL_W'(0): legal_o = (size_i == SIZE_W'(ROOT_SIZE)) &&
                                 (nls_i == NLS_W'(ROOT_WIDTH));
            LVL_W'(1),
            LVL_W'(2): legal_o = (nls_i == NLS_W'(MID_WIDTH));
            LVL_W'(DEEPEST_LVL):
                       legal_o = (nls_i == NLS_W'(MID_WIDTH)) ||
                                 (nls_i == NLS_W'(SMALL_WIDTH));
            default:   legal_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/radix_leaf_merge.sv
module radix_leaf_merge
    import radix_walk_pkg::*;
#(
    parameter int SIZE_W = 7
) (
    input  logic [ENTRY_W-1:0] ea_i,
    input  logic [ENTRY_W-1:0] entry_i,
    input  logic [SIZE_W-1:0]  size_i,
    output logic [ENTRY_W-1:0] raddr_o
);
    localparam logic [ENTRY_W-1:0] RPN_MASK =
        (ENTRY_W'(1) << (RPN_HI + 1)) - (ENTRY_W'(1) << RPN_LO);

    logic [ENTRY_W-1:0] page_mask;

    always_comb begin
        page_mask = (ENTRY_W'(1) << size_i) - ENTRY_W'(1);
        raddr_o   = (entry_i & RPN_MASK & ~page_mask) | (ea_i & page_mask);
    end
endmodule

// File: rtl/radix_walker.sv
module radix_walker
    import radix_walk_pkg::*;
#(
    parameter int SIZE_W = 7,
    parameter int NLS_W  = 5,
    parameter int LVL_W  = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [ENTRY_W-1:0]  ea_i,
    input  logic [ENTRY_W-1:0]  root_base_i,
    input  logic [NLS_W-1:0]    root_nls_i,
    input  logic [SIZE_W-1:0]   root_size_i,
    output logic                busy_o,
    output logic                mem_req_valid_o,
    input  logic                mem_req_ready_i,
    output logic [ENTRY_W-1:0]  mem_req_addr_o,
    input  logic                mem_rsp_valid_i,
    input  logic [ENTRY_W-1:0]  mem_rsp_data_i,
    output logic                done_o,
    output logic                fault_o,
    output logic [1:0]          cause_o,
    output logic [ENTRY_W-1:0]  raddr_o,
    output logic [SIZE_W-1:0]   page_size_o,
    output logic [ENTRY_W-1:0]  leaf_entry_o
);
    localparam int NB_W = NBASE_HI - NBASE_LO + 1;

    walk_state_t        state_q, state_d;
    walk_cause_t        cause_q;
    logic [ENTRY_W-1:0] ea_q, base_q, addr_q, entry_q;
    logic [NLS_W-1:0]   nls_q;
    logic [SIZE_W-1:0]  size_q;
    logic [LVL_W-1:0]   lvl_q;
    logic [ENTRY_W-1:0] entry_addr, merged;
    logic               lvl_legal;
    logic               rsp_valid_bit, rsp_leaf_bit;

    radix_entry_addr #(.SIZE_W(SIZE_W), .NLS_W(NLS_W)) addr_i (
        .ea_i   (ea_q),
        .base_i (base_q),
        .nls_i  (nls_q),
        .size_i (size_q),
        .addr_o (entry_addr)
    );

    radix_level_rule #(.SIZE_W(SIZE_W), .NLS_W(NLS_W), .LVL_W(LVL_W)) rule_i (
        .level_i (lvl_q),
        .size_i  (size_q),
        .nls_i   (nls_q),
        .legal_o (lvl_legal)
    );

    radix_leaf_merge #(.SIZE_W(SIZE_W)) merge_i (
        .ea_i    (ea_q),
        .entry_i (entry_q),
        .size_i  (size_q),
        .raddr_o (merged)
    );

    assign rsp_valid_bit = mem_rsp_data_i[VALID_BIT];
    assign rsp_leaf_bit  = mem_rsp_data_i[LEAF_BIT];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i)          state_d = ST_CHECK;
            ST_CHECK:  state_d = lvl_legal ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:  if (mem_req_ready_i)  state_d = ST_AWAIT;
            ST_AWAIT:  if (mem_rsp_valid_i)
                           state_d = (!rsp_valid_bit || rsp_leaf_bit) ? ST_FINISH : ST_CHECK;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Walk datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q    <= '0;
            base_q  <= '0;
            addr_q  <= '0;
            entry_q <= '0;
            nls_q   <= '0;
            size_q  <= '0;
            lvl_q   <= '0;
            cause_q <= CAUSE_NONE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    ea_q    <= ea_i;
                    base_q  <= root_base_i;
                    nls_q   <= root_nls_i;
                    size_q  <= root_size_i;
                    lvl_q   <= '0;
                    entry_q <= '0;
                    cause_q <= CAUSE_NONE;
                end
                ST_CHECK: begin
                    if (!lvl_legal) cause_q <= CAUSE_BAD_CFG;
                    else            addr_q  <= entry_addr;
                end
                ST_AWAIT: if (mem_rsp_valid_i) begin
                    if (!rsp_valid_bit) begin
                        cause_q <= CAUSE_NO_ENTRY;
                    end else begin
                        size_q  <= size_q - SIZE_W'(nls_q);
                        entry_q <= mem_rsp_data_i;
                        if (!rsp_leaf_bit) begin
                            base_q <= {{(ENTRY_W-NBASE_HI-1){1'b0}},
                                       mem_rsp_data_i[NBASE_HI:NBASE_LO],
                                       {NBASE_LO{1'b0}}};
                            nls_q  <= mem_rsp_data_i[NLS_W-1:0];
                            lvl_q  <= lvl_q + LVL_W'(1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o          = (state_q != ST_IDLE);
        mem_req_valid_o = (state_q == ST_ISSUE);
        mem_req_addr_o  = addr_q;
        done_o          = (state_q == ST_FINISH);
        fault_o         = (cause_q != CAUSE_NONE);
        cause_o         = cause_q;
        raddr_o         = merged;
        page_size_o     = size_q;
        leaf_entry_o    = entry_q;
    end

    logic unused_nb;
    assign unused_nb = ^NB_W;
endmodule

// File: rtl/radix_walker_chk.sv
module radix_walker_chk #(
    parameter int SIZE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              mem_req_valid_o,
    input logic              mem_req_ready_i,
    input logic [63:0]       mem_req_addr_o,
    input logic              done_o,
    input logic              fault_o,
    input logic [1:0]        cause_o,
    input logic [SIZE_W-1:0] page_size_o
);
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

    p_one_outstanding_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o && mem_req_ready_i |=> !mem_req_valid_o);

    p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_fault_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (fault_o == (cause_o != 2'd0)) && (cause_o != 2'd3));

    p_start_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o && start_i |=> busy_o);

    p_busy_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !done_o |=> busy_o);

    p_leaf_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && !fault_o |-> page_size_o >= SIZE_W'(12));
endmodule

bind radix_walker radix_walker_chk #(.SIZE_W(SIZE_W)) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .start_i         (start_i),
    .busy_o          (busy_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .done_o          (done_o),
    .fault_o         (fault_o),
    .cause_o         (cause_o),
    .page_size_o     (page_size_o)
);

// File: tb/radix_walker_tb.sv
module radix_walker_tb_top;
    localparam logic [63:0] VB = 64'h8000_0000_0000_0000;
    localparam logic [63:0] LB = 64'h4000_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] ea_i = '0, root_base_i = '0;
    logic [4:0]  root_nls_i = '0;
    logic [6:0]  root_size_i = '0;
    logic        busy_o, mem_req_valid_o, done_o, fault_o;
    logic        mem_req_ready_i, mem_rsp_valid_i;
    logic [63:0] mem_req_addr_o, mem_rsp_data_i, raddr_o, leaf_entry_o;
    logic [1:0]  cause_o;
    logic [6:0]  page_size_o;

    always #2 clk = ~clk;

    radix_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ea_i(ea_i),
        .root_base_i(root_base_i), .root_nls_i(root_nls_i), .root_size_i(root_size_i),
        .busy_o(busy_o), .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
        .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
        .mem_rsp_data_i(mem_rsp_data_i), .done_o(done_o), .fault_o(fault_o),
        .cause_o(cause_o), .raddr_o(raddr_o), .page_size_o(page_size_o),
        .leaf_entry_o(leaf_entry_o)
    );

    int checks = 0;
    int errors = 0;
    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log [0:255];
    int rd_cnt = 0;
    int done_cnt = 0;
    bit stall_mode = 1'b0;
    int stall_cnt = 0;
    bit pend = 1'b0;
    logic [63:0] pend_addr = '0;

    // Memory model: accepts at the posedge following a negedge where both
    // valid and ready are high, answers one cycle later.
    initial begin
        mem_req_ready_i = 1'b0;
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i  = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid_i = 1'b0;
            if (pend) begin
                mem_rsp_valid_i = 1'b1;
                mem_rsp_data_i  = mem.exists(pend_addr) ? mem[pend_addr] : 64'd0;
                pend = 1'b0;
            end
            stall_cnt++;
            mem_req_ready_i = stall_mode ? (stall_cnt % 3 == 0) : 1'b1;
            if (mem_req_valid_o && mem_req_ready_i) begin
                pend = 1'b1;
                pend_addr = mem_req_addr_o;
                if (rd_cnt < 256) rd_log[rd_cnt] = mem_req_addr_o;
                rd_cnt++;
            end
            if (done_o) done_cnt++;
        end
    end

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog R8 actual=no_completion expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] dir_e(input logic [63:0] base, input logic [4:0] w);
        return VB | (base & 64'h0FFF_FFFF_FFFF_FF00) | 64'(w);
    endfunction

    function automatic logic [63:0] slot(input logic [63:0] base, input logic [63:0] ea,
                                         input int sh, input int w);
        return base + (((ea >> sh) & ((64'd1 << w) - 64'd1)) << 3);
    endfunction

    logic [63:0] r_ra, r_le;
    logic [6:0]  r_ps;
    logic        r_flt;
    logic [1:0]  r_cs;
    int          r_nrd, r_first;

    task automatic walk(input logic [63:0] ea, input logic [63:0] base, input logic [4:0] w,
                        input logic [6:0] sz, input bit glitch);
        int n;
        int d0;
        r_first = rd_cnt;
        d0 = done_cnt;
        @(negedge clk);
        start_i = 1'b1; ea_i = ea; root_base_i = base; root_nls_i = w; root_size_i = sz;
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!done_o && n < 5000) begin
            @(negedge clk);
            n++;
            if (glitch && n == 2) begin
                chk("R9 busy during walk", 64'(busy_o), 64'd1);
                start_i = 1'b1; ea_i = ~ea; root_size_i = 7'd48;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        r_ra = raddr_o; r_ps = page_size_o; r_le = leaf_entry_o;
        r_flt = fault_o; r_cs = cause_o; r_nrd = rd_cnt - r_first;
        chk("R9 busy in done cycle", 64'(busy_o), 64'd1);
        @(negedge clk);
        chk("R8 done is one cycle", 64'(done_o), 64'd0);
        if (glitch) begin
            repeat (6) @(negedge clk);
            chk("R9 idle after walk", 64'(busy_o), 64'd0);
            chk("R9 single completion", 64'(done_cnt - d0), 64'd1);
        end
    endtask

    localparam logic [63:0] EA0 = 64'h0009_8765_4321_0FED;
    localparam logic [63:0] R0  = 64'h0000_0000_0010_0000;
    localparam logic [63:0] B1  = 64'h0000_0000_0020_0000;
    localparam logic [63:0] B2  = 64'h0000_0000_0030_0000;
    localparam logic [63:0] B3  = 64'h0000_0000_0040_0000;

    task automatic build_upper();
        mem.delete();
        mem[slot(R0, EA0, 39, 13)] = dir_e(B1, 5'd9);
        mem[slot(B1, EA0, 30, 9)]  = dir_e(B2, 5'd9);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", 64'(busy_o), 64'd0);
        chk("R1 done after reset", 64'(done_o), 64'd0);
        chk("R1 request after reset", 64'(mem_req_valid_o), 64'd0);
    endtask

    task automatic t_four_level(input bit glitch);
        logic [63:0] rpn, lf;
        rpn = 64'h00AB_CDEF_0123_4000;
        lf  = VB | LB | rpn | 64'h18F;
        build_upper();
        mem[slot(B2, EA0, 21, 9)] = dir_e(B3, 5'd9);
        mem[slot(B3, EA0, 12, 9)] = lf;
        walk(EA0, R0, 5'd13, 7'd52, glitch);
        chk("R7 read count 4 levels", 64'(r_nrd), 64'd4);
        chk("R2 level0 address", rd_log[r_first],     slot(R0, EA0, 39, 13));
        chk("R2 level1 address", rd_log[r_first + 1], slot(B1, EA0, 30, 9));
        chk("R4 level2 address", rd_log[r_first + 2], slot(B2, EA0, 21, 9));
        chk("R4 level3 address", rd_log[r_first + 3], slot(B3, EA0, 12, 9));
        chk("R6 real address 4K", r_ra, rpn | (EA0 & 64'hFFF));
        chk("R6 page size 12", 64'(r_ps), 64'd12);
        chk("R6 leaf entry", r_le, lf);
        chk("R8 success no fault", 64'(r_flt), 64'd0);
        chk("R8 success cause", 64'(r_cs), 64'd0);
    endtask

    task automatic t_big_leaf();
        logic [63:0] lf;
        mem.delete();
        mem[slot(R0, EA0, 39, 13)] = dir_e(B1, 5'd9);
        lf = VB | LB | 64'h0000_0055_4123_4000;
        mem[slot(B1, EA0, 30, 9)] = lf;
        walk(EA0, R0, 5'd13, 7'd52, 1'b0);
        chk("R6 reads for level1 leaf", 64'(r_nrd), 64'd2);
        chk("R6 real address 1G", r_ra, 64'h0000_0055_4000_0000 | (EA0 & 64'h3FFF_FFFF));
        chk("R4 page size 30", 64'(r_ps), 64'd30);
    endtask

    task automatic t_missing();
        build_upper();
        walk(EA0, R0, 5'd13, 7'd52, 1'b0);
        chk("R3 reads until invalid", 64'(r_nrd), 64'd3);
        chk("R3 fault flag", 64'(r_flt), 64'd1);
        chk("R3 cause no entry", 64'(r_cs), 64'd1);
    endtask

    task automatic t_root_cfg();
        build_upper();
        walk(EA0, R0, 5'd13, 7'd48, 1'b0);
        chk("R5 root size rejected no read", 64'(r_nrd), 64'd0);
        chk("R5 root cause", 64'(r_cs), 64'd2);
        walk(EA0, R0, 5'd9, 7'd52, 1'b0);
        chk("R5 root width rejected", 64'(r_cs), 64'd2);
    endtask

    task automatic t_small_l3();
        logic [63:0] rpn;
        rpn = 64'h0000_0777_0000_0000;
        build_upper();
        mem[slot(B2, EA0, 21, 9)] = dir_e(B3, 5'd5);
        mem[slot(B3, EA0, 16, 5)] = VB | LB | rpn | 64'hF000;
        walk(EA0, R0, 5'd13, 7'd52, 1'b0);
        chk("R5 level3 width5 address", rd_log[r_first + 3], slot(B3, EA0, 16, 5));
        chk("R5 level3 width5 size", 64'(r_ps), 64'd16);
        chk("R6 real address 64K", r_ra, rpn | (EA0 & 64'hFFFF));
        chk("R5 level3 width5 ok", 64'(r_flt), 64'd0);
    endtask

    task automatic t_bad_l3();
        build_upper();
        mem[slot(B2, EA0, 21, 9)] = dir_e(B3, 5'd7);
        walk(EA0, R0, 5'd13, 7'd52, 1'b0);
        chk("R5 level3 width7 reads", 64'(r_nrd), 64'd3);
        chk("R5 level3 width7 cause", 64'(r_cs), 64'd2);
    endtask

    task automatic t_too_deep();
        build_upper();
        mem[slot(B2, EA0, 21, 9)] = dir_e(B3, 5'd9);
        mem[slot(B3, EA0, 12, 9)] = dir_e(64'h50_0000, 5'd9);
        walk(EA0, R0, 5'd13, 7'd52, 1'b0);
        chk("R5 level4 reads", 64'(r_nrd), 64'd4);
        chk("R5 level4 cause", 64'(r_cs), 64'd2);
        chk("R5 level4 fault", 64'(r_flt), 64'd1);
    endtask

    task automatic t_misalign();
        mem.delete();
        mem[slot(R0, EA0, 39, 13)] = dir_e(B1 | 64'hF00, 5'd9);
        mem[slot(B1, EA0, 30, 9)]  = VB | LB | 64'h0000_0011_0000_0000;
        walk(EA0, R0 | 64'hABF8, 5'd13, 7'd52, 1'b0);
        chk("R2 root base low bits cleared", rd_log[r_first], slot(R0, EA0, 39, 13));
        chk("R2 dir base low bits cleared", rd_log[r_first + 1], slot(B1, EA0, 30, 9));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four_level(1'b0);
        t_big_leaf();
        t_missing();
        t_root_cfg();
        t_small_l3();
        t_bad_l3();
        t_too_deep();
        t_misalign();
        stall_mode = 1'b1;      // R7 backpressure with R9 start while busy
        t_four_level(1'b1);
        stall_mode = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule